// File: doc/BRIEF.md
# Banked Cartridge Memory Controller

This block sits on an 8-bit processor bus with a 16-bit address. It turns that address space into physical addresses for an external banked ROM and an external banked RAM. The lower 16 KiB window always shows the start of the ROM. The next 16 KiB window shows a ROM bank that software picks. An 8 KiB window higher up shows one RAM bank. The block holds no memory contents of its own. It drives the ROM and RAM addresses and chip selects, and it passes read data back to the bus. When the selected bank does not exist, a read returns zero.

Software programs the controller by writing into the ROM address range. The address range of the write picks the target: a RAM-enable flag, the low five bits of the ROM bank, a two-bit auxiliary field, or a mode bit. In ROM-banking mode, the auxiliary field supplies ROM bank bits 6:5. In RAM-banking mode, the auxiliary field supplies the RAM bank. When the mode changes, the two auxiliary bits move from one place to the other. The parameters `ROM_BANKS` and `RAM_BANKS` give the number of banks fitted. Setting `RAM_BANKS` to 0 means no RAM is present.

Top module: `cbc_top`

## Requirements
- R1: A write to 0x0000–0x1FFF sets the RAM-enable flag if the data byte is 0x0A and clears it for any other value.
- R2: A write to 0x2000–0x3FFF puts data bits 4:0 into ROM bank bits 4:0 and leaves ROM bank bits 6:5 unchanged.
- R3: If the written low field is zero, ROM bank bit 0 is forced to 1. Written values 0x00, 0x20, 0x40 and 0x60 therefore select banks 1, 0x21, 0x41 and 0x61, and ROM bank bits 4:0 are never zero.
- R4: A write to 0x4000–0x5FFF stores data bits 1:0. In RAM-banking mode they become the RAM bank. In ROM-banking mode they become ROM bank bits 6:5. The other register is not changed.
- R5: A write to 0x6000–0x7FFF selects the mode from data bit 0 (0 = ROM banking, 1 = RAM banking). Writing the mode that is already set changes no register.
- R6: On a change into ROM-banking mode, the RAM bank moves into ROM bank bits 6:5, and the RAM bank becomes 0.
- R7: On a change into RAM-banking mode, ROM bank bits 6:5 move into the RAM bank, and those ROM bits become 0.
- R8: A read from 0x0000–0x3FFF asserts rom_cs with rom_addr equal to the address. A read from 0x4000–0x7FFF drives rom_addr = (bank << 14) + (address − 0x4000). rom_cs is never asserted on a write. rom_addr is 21 bits wide.
- R9: An access to 0xA000–0xBFFF asserts ram_cs with ram_addr = (RAM bank << 13) + (address − 0xA000), but only if RAM is present and enabled. ram_we follows cpu_wr during such an access. ram_addr is 15 bits wide.
- R10: If the selected ROM bank is ≥ ROM_BANKS, or the selected RAM bank is ≥ RAM_BANKS, no chip select is asserted and cpu_rdata is 0.
- R11: After reset, the ROM bank is 1, the RAM bank is 0, the mode is ROM banking and RAM is disabled. Accesses outside the decoded windows assert no chip select, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Bus write data |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data returned to the bus |
| rom_rdata | input | 8 | Data from external ROM |
| ram_rdata | input | 8 | Data from external RAM |
| rom_addr | output | 21 | Physical ROM address |
| rom_cs | output | 1 | ROM chip select |
| ram_addr | output | 15 | Physical RAM address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |

## Verification
The only way to see the bank registers is through the next access to the switchable windows. A wrong bank value shows up as a wrong rom_addr or ram_addr bit pattern. A wrong enable or bank-range decision shows up as a missing or extra chip select. Both appear combinationally on the first read after the faulty register write. Mode-switch bugs are hidden until an access reaches both windows, so the bench reads both the ROM window and the RAM window right after every mode change.

// File: rtl/cbc_pkg.sv
// Package: shared widths and the address-region type for the bank controller.
// Assumes a 16-bit bus address with fixed 16 KiB ROM and 8 KiB RAM windows.
package cbc_pkg;
    localparam int ROM_LO_W   = 5;
    localparam int AUX_W      = 2;
    localparam int ROM_BANK_W = ROM_LO_W + AUX_W;
    localparam int ROM_OFS_W  = 14;
    localparam int RAM_OFS_W  = 13;
    localparam int ROM_AW     = ROM_BANK_W + ROM_OFS_W;
    localparam int RAM_AW     = AUX_W + RAM_OFS_W;
    localparam logic [7:0] EN_KEY = 8'h0A;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ENABLE,
        RG_ROM_LO,
        RG_AUX,
        RG_MODE,
        RG_ROM_FIX,
        RG_ROM_SW,
        RG_RAM
    } region_t;

    typedef enum logic {
        MD_ROM = 1'b0,
        MD_RAM = 1'b1
    } bank_mode_t;
endpackage

// File: rtl/cbc_decode.sv
// Module: address decoder. Classifies the bus address into a write target
// and a read window. Purely combinational; assumes one strobe at a time.
module cbc_decode
    import cbc_pkg::*;
(
    input  logic [15:0] addr,
    output region_t     wr_region,
    output region_t     rd_region
);
    // Write target: four 8 KiB register ranges in the lower half.
    always_comb begin
        unique case (addr[15:13])
            3'd0:    wr_region = RG_ENABLE;
            3'd1:    wr_region = RG_ROM_LO;
            3'd2:    wr_region = RG_AUX;
            3'd3:    wr_region = RG_MODE;
            3'd5:    wr_region = RG_RAM;
            default: wr_region = RG_NONE;
        endcase
    end

    // Read window: fixed ROM, switchable ROM, RAM, or nothing.
    always_comb begin
        if (addr[15:14] == 2'b00)      rd_region = RG_ROM_FIX;
        else if (addr[15:14] == 2'b01) rd_region = RG_ROM_SW;
        else if (addr[15:13] == 3'd5)  rd_region = RG_RAM;
        else                           rd_region = RG_NONE;
    end
endmodule

// File: rtl/cbc_regs.sv
// Module: bank register file. Holds the RAM enable, the ROM low field,
// the shared two-bit field in its current home, and the mode bit.
// Assumes wr_region is valid only while wr_stb is high.
module cbc_regs
    import cbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  region_t               wr_region,
    input  logic [7:0]            wdata,
    output logic                  ram_en,
    output logic [ROM_LO_W-1:0]   rom_lo,
    output logic [AUX_W-1:0]      rom_hi,
    output logic [AUX_W-1:0]      ram_bank,
    output bank_mode_t            mode
);
    logic [ROM_LO_W-1:0] lo_fixed;
    bank_mode_t          mode_req;

    // Remap a zero low field to one.
    always_comb begin
        lo_fixed = wdata[ROM_LO_W-1:0];
        if (lo_fixed == '0) lo_fixed = ROM_LO_W'(1);
    end

    // Decode the requested mode from data bit 0.
    assign mode_req = bank_mode_t'(wdata[0]);

    // Register update on bus writes, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_en   <= 1'b0;
            rom_lo   <= ROM_LO_W'(1);
            rom_hi   <= '0;
            ram_bank <= '0;
            mode     <= MD_ROM;
        end else if (wr_stb) begin
            case (wr_region)
                RG_ENABLE: ram_en <= (wdata == EN_KEY);
                RG_ROM_LO: rom_lo <= lo_fixed;
                RG_AUX: begin
                    if (mode == MD_RAM) ram_bank <= wdata[AUX_W-1:0];
                    else                rom_hi   <= wdata[AUX_W-1:0];
                end
                RG_MODE: begin
                    if (mode_req != mode) begin
                        mode <= mode_req;
                        if (mode_req == MD_RAM) begin
                            ram_bank <= rom_hi;
                            rom_hi   <= '0;
                        end else begin
                            rom_hi   <= ram_bank;
                            ram_bank <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cbc_map.sv
// Module: physical address mapper. Forms ROM and RAM addresses, chip
// selects and read data, and blocks any bank beyond the fitted count.
// Combinational; assumes registers come from cbc_regs.
module cbc_map
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4
)(
    input  logic [15:0]           addr,
    input  logic                  rd,
    input  logic                  wr,
    input  region_t               rd_region,
    input  logic                  ram_en,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    input  logic [AUX_W-1:0]      ram_bank,
    input  logic [7:0]            rom_rdata,
    input  logic [7:0]            ram_rdata,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic                  rom_cs,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic                  ram_cs,
    output logic                  ram_we,
    output logic [7:0]            rdata
);
    localparam int ROM_LIM = ROM_BANKS;
    localparam int RAM_LIM = RAM_BANKS;

    logic rom_ok;
    logic ram_ok;

    // Bank range checks against the fitted counts.
    always_comb begin
        rom_ok = (32'(rom_bank) < ROM_LIM);
        ram_ok = (RAM_LIM > 0) && (32'(ram_bank) < RAM_LIM) && ram_en;
    end

    // ROM address and select; fixed window always reaches bank 0.
    always_comb begin
        rom_addr = '0;
        rom_cs   = 1'b0;
        if (rd_region == RG_ROM_FIX) begin
            rom_addr = ROM_AW'(addr[ROM_OFS_W-1:0]);
            rom_cs   = rd;
        end else if (rd_region == RG_ROM_SW) begin
            rom_addr = {rom_bank, addr[ROM_OFS_W-1:0]};
            rom_cs   = rd && rom_ok;
        end
    end

    // RAM address, select and write enable.
    always_comb begin
        ram_addr = {ram_bank, addr[RAM_OFS_W-1:0]};
        ram_cs   = (rd_region == RG_RAM) && (rd || wr) && ram_ok;
        ram_we   = ram_cs && wr;
    end

    // Read data return; zero when nothing is selected.
    always_comb begin
        if (rom_cs)                rdata = rom_rdata;
        else if (ram_cs && rd)     rdata = ram_rdata;
        else                       rdata = '0;
    end
endmodule

// File: rtl/cbc_top.sv
// Module: top of the cartridge bank controller. Connects decoder, register
// file and mapper. Register writes take effect at the clock edge; address
// outputs follow the bus combinationally.
module cbc_top
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [7:0]        cpu_rdata,
    input  logic [7:0]        rom_rdata,
    input  logic [7:0]        ram_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_cs,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs,
    output logic              ram_we
);
    region_t             wr_region;
    region_t             rd_region;
    logic                ram_en;
    logic [ROM_LO_W-1:0] rom_lo;
    logic [AUX_W-1:0]    rom_hi;
    logic [AUX_W-1:0]    ram_bank;
    bank_mode_t          mode;
    logic                reg_wr;

    // Register writes only land in the lower half of the map.
    assign reg_wr = cpu_wr && !cpu_addr[15];

    cbc_decode u_dec (
        .addr      (cpu_addr),
        .wr_region (wr_region),
        .rd_region (rd_region)
    );

    cbc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (reg_wr),
        .wr_region (wr_region),
        .wdata     (cpu_wdata),
        .ram_en    (ram_en),
        .rom_lo    (rom_lo),
        .rom_hi    (rom_hi),
        .ram_bank  (ram_bank),
        .mode      (mode)
    );

    cbc_map #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_map (
        .addr      (cpu_addr),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .rd_region (rd_region),
        .ram_en    (ram_en),
        .rom_bank  ({rom_hi, rom_lo}),
        .ram_bank  (ram_bank),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .rom_cs    (rom_cs),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .rdata     (cpu_rdata)
    );
endmodule

// File: rtl/cbc_checker.sv
// Module: property checker for cbc_top, attached by bind below.
module cbc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input logic [7:0]  cpu_rdata,
    input logic        rom_cs,
    input logic        ram_cs,
    input logic        ram_we,
    input logic        ram_en,
    input logic [4:0]  rom_lo,
    input logic [1:0]  rom_hi,
    input logic [1:0]  ram_bank,
    input logic        mode
);
    AST_EN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'd0) |=> (ram_en == ($past(cpu_wdata) == 8'h0A))); // R1
    AST_LO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rom_lo != 5'd0); // R3
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'd1) |=> $stable(rom_hi)); // R2
    AST_MODE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'd3 && cpu_wdata[0] == mode)
        |=> ($stable(rom_hi) && $stable(ram_bank))); // R5
    AST_ROM_CS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (cpu_rd && !cpu_addr[15])); // R8
    AST_RAM_WE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && cpu_wr && ram_en)); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !rom_cs && !ram_cs) |-> (cpu_rdata == 8'h00)); // R10
    AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs)); // R11
endmodule

bind cbc_top cbc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_en    (ram_en),
    .rom_lo    (rom_lo),
    .rom_hi    (rom_hi),
    .ram_bank  (ram_bank),
    .mode      (mode)
);

// File: tb/sim_cbc_top.sv
module sim_cbc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  rom_rdata = 8'hA5;
    logic [7:0]  ram_rdata = 8'h3C;
    logic [20:0] rom_addr;
    logic        rom_cs;
    logic [14:0] ram_addr;
    logic        ram_cs;
    logic        ram_we;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cbc_top #(.ROM_BANKS(64), .RAM_BANKS(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_addr),
        .rom_cs(rom_cs), .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Bus write; checks selects during the write cycle.
    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        if (!a[15]) check("R8", "rom_cs on write", 32'(rom_cs), 32'd0);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Bus read; outputs are combinational, sampled after settling.
    task automatic bus_rd(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
    endtask

    task automatic rd_end();
        cpu_rd = 1'b0;
    endtask

    task automatic t_reset();
        bus_rd(16'h4000);
        check("R11", "reset rom_addr", 32'(rom_addr), 32'h04000);
        check("R11", "reset rom_cs", 32'(rom_cs), 32'd1);
        bus_rd(16'hA000);
        check("R11", "reset ram disabled", 32'(ram_cs), 32'd0);
        check("R11", "reset ram read zero", 32'(cpu_rdata), 32'h00);
        bus_rd(16'h8000);
        check("R11", "unmapped rom_cs", 32'(rom_cs), 32'd0);
        check("R11", "unmapped ram_cs", 32'(ram_cs), 32'd0);
        rd_end();
    endtask

    task automatic t_rom_map();
        bus_rd(16'h1234);
        check("R8", "fixed rom_addr", 32'(rom_addr), 32'h01234);
        check("R8", "fixed rdata", 32'(cpu_rdata), 32'hA5);
        rd_end();
        bus_wr(16'h2000, 8'h05);
        bus_rd(16'h7FFF);
        check("R8", "banked rom_addr", 32'(rom_addr), 32'h17FFF);
        rd_end();
    endtask

    task automatic t_zero();
        bus_wr(16'h2100, 8'h00);
        bus_rd(16'h4000);
        check("R3", "zero->1", 32'(rom_addr), 32'h04000);
        rd_end();
        bus_wr(16'h3FFF, 8'hE0);
        bus_rd(16'h4000);
        check("R3", "0xE0->1", 32'(rom_addr), 32'h04000);
        rd_end();
    endtask

    task automatic t_hi();
        bus_wr(16'h4000, 8'h01);
        bus_wr(16'h2000, 8'h03);
        bus_rd(16'h4000);
        check("R2", "hi kept bank 0x23", 32'(rom_addr), 32'h8C000);
        rd_end();
        bus_wr(16'h2000, 8'h20);
        bus_rd(16'h4000);
        check("R3", "0x20 with hi=1 -> 0x21", 32'(rom_addr), 32'h84000);
        rd_end();
    endtask

    task automatic t_oor();
        bus_wr(16'h5000, 8'h02);
        bus_rd(16'h4000);
        check("R4", "rom mode aux -> rom_addr bank 0x41", 32'(rom_addr), 32'h104000);
        check("R10", "bank 0x41 no rom_cs", 32'(rom_cs), 32'd0);
        check("R10", "bank 0x41 rdata zero", 32'(cpu_rdata), 32'h00);
        bus_rd(16'h0100);
        check("R8", "fixed window still selected", 32'(rom_cs), 32'd1);
        rd_end();
    endtask

    task automatic t_to_ram_mode();
        bus_wr(16'h6000, 8'h01);
        bus_rd(16'h4000);
        check("R7", "hi cleared on ram mode", 32'(rom_addr), 32'h04000);
        rd_end();
        bus_wr(16'h0000, 8'h0A);
        bus_rd(16'hA000);
        check("R7", "ram bank 2 moved in, out of range", 32'(ram_addr), 32'h4000);
        check("R10", "ram bank 2 no ram_cs", 32'(ram_cs), 32'd0);
        check("R10", "ram bank 2 rdata zero", 32'(cpu_rdata), 32'h00);
        rd_end();
        bus_wr(16'h4000, 8'h01);
        bus_rd(16'hA123);
        check("R9", "ram_addr bank1", 32'(ram_addr), 32'h2123);
        check("R9", "ram_cs", 32'(ram_cs), 32'd1);
        check("R9", "ram rdata", 32'(cpu_rdata), 32'h3C);
        rd_end();
        bus_rd(16'h4000);
        check("R4", "rom bank untouched in ram mode", 32'(rom_addr), 32'h04000);
        rd_end();
    endtask

    task automatic t_same_mode();
        bus_wr(16'h7000, 8'h03);
        bus_rd(16'hA000);
        check("R5", "same mode keeps ram bank", 32'(ram_addr), 32'h2000);
        rd_end();
        bus_rd(16'h4000);
        check("R5", "same mode keeps rom bank", 32'(rom_addr), 32'h04000);
        rd_end();
    endtask

    task automatic t_to_rom_mode();
        bus_wr(16'h6000, 8'h00);
        bus_rd(16'h4000);
        check("R6", "ram bank -> rom hi", 32'(rom_addr), 32'h84000);
        rd_end();
        bus_rd(16'hA000);
        check("R6", "ram bank cleared", 32'(ram_addr), 32'h0000);
        check("R6", "ram_cs bank0", 32'(ram_cs), 32'd1);
        rd_end();
    endtask

    task automatic t_ram_write();
        @(negedge clk);
        cpu_addr = 16'hBFFF; cpu_wdata = 8'h77; cpu_wr = 1'b1;
        #1;
        check("R9", "write ram_cs", 32'(ram_cs), 32'd1);
        check("R9", "write ram_we", 32'(ram_we), 32'd1);
        check("R9", "write ram_addr", 32'(ram_addr), 32'h1FFF);
        @(negedge clk);
        cpu_wr = 1'b0;
        bus_wr(16'h1000, 8'h0B);
        bus_rd(16'hA000);
        check("R1", "non-key disables", 32'(ram_cs), 32'd0);
        check("R1", "disabled rdata zero", 32'(cpu_rdata), 32'h00);
        rd_end();
        bus_wr(16'h1FFF, 8'h0A);
        bus_rd(16'hA000);
        check("R1", "key enables", 32'(ram_cs), 32'd1);
        rd_end();
        bus_rd(16'hC000);
        check("R11", "0xC000 no select", 32'(rom_cs | ram_cs), 32'd0);
        check("R11", "0xC000 rdata zero", 32'(cpu_rdata), 32'h00);
        rd_end();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rom_map();
        t_zero();
        t_hi();
        t_oor();
        t_to_ram_mode();
        t_same_mode();
        t_to_rom_mode();
        t_ram_write();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule